// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block steps a successive-approximation converter through a contiguous set of channels, starting at channel 0, over and over for as long as software keeps the start enable at 1. Software writes a start value and the index of the last channel of the set. The sequencer then drives a channel select, a sampling-window strobe and a one-cycle convert strobe to the converter. It takes back a completion pulse and a result word, and stores each word in that channel's own result register. The converter itself is outside the block. It is abstract: it answers a convert strobe with a completion pulse some cycles later.

The first conversion after a start is preceded by a start delay. The length of that delay depends on the phase of a free-running prescaler at the moment of the start write, so the total time of a first conversion varies within a bounded range. Every later conversion in the scan skips the delay and begins sampling in the cycle right after the previous result is taken. A write of start = 0 parks the block in its wait state and drops any conversion in flight. A new start always begins at channel 0. When the last channel of the set is stored, a done flag is set and an interrupt pulse fires. Software clears the flag by reading it while it is 1 and then writing a clear.

The sequencer has four states. WAIT is idle. DELAY counts the start delay. SAMPLE holds the sampling window. CONVERT waits for the completion pulse. The transitions are:

- WAIT to DELAY on a start write.
- DELAY to SAMPLE when the delay count expires.
- SAMPLE to CONVERT when the window count expires.
- CONVERT to SAMPLE on an accepted completion, for the next channel or the wrap to channel 0.
- DELAY, SAMPLE or CONVERT to WAIT on a stop write.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block is in WAIT. smp_en, conv_go, irq and done_flag are 0, ch_sel is 0 and every result register reads 0.
- R2: A write with cfg_start = 1 in WAIT begins a scan. Let p be the number of rising clock edges since reset release, taken at the write edge, with the first edge after release counted as 0. The start delay is D = DLY_MIN + (p mod (DLY_MAX - DLY_MIN + 1)) cycles, and smp_en rises D clock edges after the write edge.
- R3: smp_en stays high for exactly SMP_CYC cycles. conv_go is a single-cycle pulse in the cycle right after the window, and it never overlaps smp_en.
- R4: A conv_done pulse seen in CONVERT stores conv_data in the result register of the current ch_sel. A conv_done at any other time changes no result register. rd_data shows the register selected by rd_ch in the same cycle.
- R5: Channels are converted in ascending order from 0 to the set's last index, then the scan wraps to 0. Every conversion after the first of a scan begins its sampling window in the cycle after the completion is accepted, with no start delay.
- R6: The last index is taken from cfg_last at the start write. A value above NCH-1 is clamped to NCH-1.
- R7: A write with cfg_start = 0 puts the block in WAIT on the next cycle, with smp_en and conv_go low. A conversion in flight is dropped: its result is not stored and done_flag is not set.
- R8: A start after a stop begins at channel 0 and again waits a start delay computed as in R2.
- R9: Storing the result of the last channel of the set sets done_flag. In the same cycle irq goes high for one cycle (IRQ_EN = 1).
- R10: A flag_clr pulse clears done_flag only if a flag_rd pulse saw done_flag = 1 earlier. A flag_clr without such a read leaves the flag at 1.
- R11: A start write while a scan is running has no effect. In particular it does not restart or lengthen the start delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_start | input | 1 | Start enable value written with cfg_wr |
| cfg_last | input | CH_W | Last channel index of the set, written with cfg_wr |
| flag_rd | input | 1 | Status read strobe; arms the flag clear when done_flag is 1 |
| flag_clr | input | 1 | Write-zero strobe for done_flag |
| conv_done | input | 1 | Completion pulse from the converter |
| conv_data | input | DW | Result word from the converter, valid with conv_done |
| rd_ch | input | CH_W | Result register selector |
| smp_en | output | 1 | High during the sampling window |
| conv_go | output | 1 | One-cycle convert strobe |
| ch_sel | output | CH_W | Channel under conversion |
| rd_data | output | DW | Content of the result register chosen by rd_ch |
| done_flag | output | 1 | Scan-complete flag |
| irq | output | 1 | One-cycle interrupt pulse at scan completion |

## Verification
The bench builds the block with NCH = 3, DLY_MIN = 2, DLY_MAX = 5, SMP_CYC = 3 and a converter stub of four cycles of latency. With these values the 2-bit channel field can hold index 3, which lies above the top channel, so the clamp of R6 comes into play. The four possible delay phases are swept for every set size from one to three channels, so each delay length is measured against the arithmetic of R2 for every set. Two full passes per run check the wrap and the shorter later timing. A stop placed inside a conversion then shows that the result is dropped and that the restart begins again from channel 0.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_DELAY   = 2'd1,
        ST_SAMPLE  = 2'd2,
        ST_CONVERT = 2'd3
    } seq_state_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adc_delay_pick.sv
module adc_delay_pick #(
    parameter int DLY_MIN = 2,
    parameter int DLY_MAX = 5,
    parameter int DLY_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DLY_W-1:0] dly_len
);
    localparam int SPAN = DLY_MAX - DLY_MIN + 1;
    localparam int PW   = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [PW-1:0] PH_TOP = PW'(SPAN - 1);

    logic [PW-1:0] phase_q;

    // Free-running phase counter; its value at the start write picks the delay.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == PH_TOP) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    assign dly_len = DLY_W'(DLY_MIN) + DLY_W'(phase_q);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NCH  = 8,
    parameter int DW   = 12,
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  logic [DW-1:0]   wr_data,
    input  logic [CH_W-1:0] rd_ch,
    output logic [DW-1:0]   rd_data
);
    localparam logic [CH_W-1:0] TOP_CH = CH_W'(NCH - 1);

    logic [DW-1:0] res_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [CH_W-1:0] MY_CH = CH_W'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[g] <= '0;
            end else if (wr_en && (wr_ch == MY_CH)) begin
                res_q[g] <= wr_data;
            end
        end

        // R4: a register only changes on a store aimed at it
        a_r4_hold_unless_written: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_ch == MY_CH)) |=> $stable(res_q[g]));
    end

    always_comb begin
        rd_data = '0;
        if (rd_ch <= TOP_CH) begin
            rd_data = res_q[rd_ch];
        end
    end

endmodule

// File: rtl/adc_done_flag.sv
module adc_done_flag #(
    parameter int IRQ_EN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic flag_rd,
    input  logic flag_clr,
    output logic done_flag,
    output logic irq
);
    logic done_q;
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_evt) begin
            done_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (flag_clr && armed_q) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (flag_rd && done_q) begin
            armed_q <= 1'b1;
        end
    end

    if (IRQ_EN != 0) begin : g_irq
        logic irq_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_q <= 1'b0;
            end else begin
                irq_q <= set_evt;
            end
        end
        assign irq = irq_q;
    end else begin : g_no_irq
        assign irq = 1'b0;
    end

    assign done_flag = done_q;

    // R9: a scan-end event always leaves the flag set
    a_r9_set_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> done_flag);

    // R10: the flag only drops after an armed clear
    a_r10_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> ($past(flag_clr) && $past(armed_q)));

    // R9: the interrupt pulse lasts a single cycle
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_scan_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int CH_W    = 3,
    parameter int SMP_CYC = 4,
    parameter int DLY_W   = 3,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_start,
    input  logic [CH_W-1:0]  cfg_last,
    input  logic [DLY_W-1:0] dly_len,
    input  logic             conv_done,
    output logic             smp_en,
    output logic             conv_go,
    output logic [CH_W-1:0]  ch_sel,
    output logic             res_wr,
    output logic             scan_end
);
    localparam logic [CH_W-1:0]  TOP_CH   = CH_W'(NCH - 1);
    localparam logic [CNT_W-1:0] SMP_LOAD = CNT_W'(SMP_CYC - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  ch_q;
    logic [CH_W-1:0]  last_q;
    logic             smp_q;
    logic             go_q;
    logic             stop_req;
    logic             go_req;
    logic             take;

    assign stop_req = cfg_wr && !cfg_start;
    assign go_req   = cfg_wr && cfg_start;
    // A stop in the same cycle as a completion wins: the result is dropped.
    assign take     = (state == ST_CONVERT) && conv_done && !stop_req;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT: begin
                if (go_req) nxt = ST_DELAY;
            end
            ST_DELAY: begin
                if (stop_req)            nxt = ST_WAIT;
                else if (cnt_q == '0)    nxt = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (stop_req)            nxt = ST_WAIT;
                else if (cnt_q == '0)    nxt = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (stop_req)            nxt = ST_WAIT;
                else if (conv_done)      nxt = ST_SAMPLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= nxt;
        end
    end

    // Counter, channel pointer and latched set size
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ch_q   <= '0;
            last_q <= '0;
        end else if (stop_req && (state != ST_WAIT)) begin
            cnt_q <= '0;
            ch_q  <= '0;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (go_req) begin
                        cnt_q  <= CNT_W'(dly_len) - CNT_W'(1);
                        ch_q   <= '0;
                        last_q <= (cfg_last > TOP_CH) ? TOP_CH : cfg_last;
                    end
                end
                ST_DELAY: begin
                    cnt_q <= (cnt_q == '0) ? SMP_LOAD : cnt_q - CNT_W'(1);
                end
                ST_SAMPLE: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_CONVERT: begin
                    if (take) begin
                        cnt_q <= SMP_LOAD;
                        ch_q  <= (ch_q == last_q) ? '0 : ch_q + CH_W'(1);
                    end
                end
            endcase
        end
    end

    // Registered strobes, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
            go_q  <= 1'b0;
        end else begin
            smp_q <= (nxt == ST_SAMPLE);
            go_q  <= (nxt == ST_CONVERT) && (state != ST_CONVERT);
        end
    end

    assign smp_en   = smp_q;
    assign conv_go  = go_q;
    assign ch_sel   = ch_q;
    assign res_wr   = take;
    assign scan_end = take && (ch_q == last_q);

    // R7: a stop write parks the sequencer with strobes low
    a_r7_stop_parks: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (state == ST_WAIT && !smp_en && !conv_go));

    // R3: the convert strobe follows a sampling cycle directly
    a_r3_go_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> $past(smp_en));

    // R3: the convert strobe is one cycle wide
    a_r3_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |=> !conv_go);

    // R3: window and strobe are exclusive
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_en && conv_go));

    // R6: the pointer never leaves the latched set
    a_r6_ch_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        ch_sel <= last_q);

    // R8: the start delay always belongs to channel 0
    a_r8_delay_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY) |-> (ch_sel == '0));

    // R5: completing the last channel wraps to channel 0
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        scan_end |=> (ch_sel == '0));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int DW      = 12,
    parameter int DLY_MIN = 2,
    parameter int DLY_MAX = 5,
    parameter int SMP_CYC = 4,
    parameter int IRQ_EN  = 1,
    localparam int CH_W   = idx_width(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic            cfg_start,
    input  logic [CH_W-1:0] cfg_last,
    input  logic            flag_rd,
    input  logic            flag_clr,
    input  logic            conv_done,
    input  logic [DW-1:0]   conv_data,
    input  logic [CH_W-1:0] rd_ch,
    output logic            smp_en,
    output logic            conv_go,
    output logic [CH_W-1:0] ch_sel,
    output logic [DW-1:0]   rd_data,
    output logic            done_flag,
    output logic            irq
);
    localparam int DLY_W = $clog2(DLY_MAX + 1);
    localparam int CMAX  = (DLY_MAX > SMP_CYC) ? DLY_MAX : SMP_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);

    logic [DLY_W-1:0] dly_len;
    logic             res_wr;
    logic             scan_end;

    adc_delay_pick #(
        .DLY_MIN (DLY_MIN),
        .DLY_MAX (DLY_MAX),
        .DLY_W   (DLY_W)
    ) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .dly_len (dly_len)
    );

    adc_seq_fsm #(
        .NCH     (NCH),
        .CH_W    (CH_W),
        .SMP_CYC (SMP_CYC),
        .DLY_W   (DLY_W),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_start (cfg_start),
        .cfg_last  (cfg_last),
        .dly_len   (dly_len),
        .conv_done (conv_done),
        .smp_en    (smp_en),
        .conv_go   (conv_go),
        .ch_sel    (ch_sel),
        .res_wr    (res_wr),
        .scan_end  (scan_end)
    );

    adc_result_bank #(
        .NCH  (NCH),
        .DW   (DW),
        .CH_W (CH_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_wr),
        .wr_ch   (ch_sel),
        .wr_data (conv_data),
        .rd_ch   (rd_ch),
        .rd_data (rd_data)
    );

    adc_done_flag #(
        .IRQ_EN (IRQ_EN)
    ) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (scan_end),
        .flag_rd   (flag_rd),
        .flag_clr  (flag_clr),
        .done_flag (done_flag),
        .irq       (irq)
    );

endmodule

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
    localparam int NCH     = 3;
    localparam int DW      = 16;
    localparam int DLY_MIN = 2;
    localparam int DLY_MAX = 5;
    localparam int SMP_CYC = 3;
    localparam int LAT     = 4;
    localparam int SPAN    = DLY_MAX - DLY_MIN + 1;
    localparam int CH_W    = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr = 1'b0;
    logic            cfg_start = 1'b0;
    logic [CH_W-1:0] cfg_last = '0;
    logic            flag_rd = 1'b0;
    logic            flag_clr = 1'b0;
    logic            conv_done = 1'b0;
    logic [DW-1:0]   conv_data = '0;
    logic [CH_W-1:0] rd_ch = '0;
    logic            smp_en, conv_go, done_flag, irq;
    logic [CH_W-1:0] ch_sel;
    logic [DW-1:0]   rd_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int pend = 0;
    int seq = 0;

    always #2 clk = ~clk;

    adc_scan_seq #(
        .NCH(NCH), .DW(DW), .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX),
        .SMP_CYC(SMP_CYC), .IRQ_EN(1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
        .cfg_last(cfg_last), .flag_rd(flag_rd), .flag_clr(flag_clr),
        .conv_done(conv_done), .conv_data(conv_data), .rd_ch(rd_ch),
        .smp_en(smp_en), .conv_go(conv_go), .ch_sel(ch_sel), .rd_data(rd_data),
        .done_flag(done_flag), .irq(irq)
    );

    // Edge count since reset release, for the R2 delay arithmetic
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Converter stub: completion LAT cycles after the convert strobe
    always @(posedge clk) begin
        #1;
        conv_done = 1'b0;
        if (conv_go) begin
            pend = LAT;
        end else if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                conv_data = DW'(16'h5000 + seq * 8 + int'(ch_sel));
                conv_done = 1'b1;
                seq = seq + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_scan(input int last, input bit retrig, input string req);
        int d;
        int n;
        d = DLY_MIN + (cyc % SPAN);
        cfg_last = CH_W'(last);
        cfg_start = 1'b1;
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
        n = 1;
        while (!smp_en && n < 100) begin
            cfg_wr = (retrig && n == 2);
            step();
            n++;
        end
        cfg_wr = 1'b0;
        // smp_en rises D edges after the write edge, i.e. at n = D+1
        chk(n == d + 1, retrig ? "R11 delay not restarted" : req, n, d + 1);
    endtask

    task automatic conv_body(input int ch, input int eff, input bit first);
        int m;
        int g;
        logic [DW-1:0] data;
        if (!first) chk(smp_en == 1'b1, "R5 no delay on later conversion", int'(smp_en), 1);
        chk(int'(ch_sel) == ch, first ? "R8 first channel" : "R5 channel order", int'(ch_sel), ch);
        m = 0;
        while (smp_en && m < 50) begin
            m++;
            step();
        end
        chk(m == SMP_CYC, "R3 window length", m, SMP_CYC);
        chk(conv_go == 1'b1, "R3 convert strobe after window", int'(conv_go), 1);
        step();
        chk(conv_go == 1'b0, "R3 strobe single cycle", int'(conv_go), 0);
        g = 0;
        while (!conv_done && g < 100) begin
            step();
            g++;
        end
        data = conv_data;
        step();
        rd_ch = CH_W'(ch);
        #0.1;
        chk(rd_data == data, "R4 result stored", int'(rd_data), int'(data));
        if (ch == eff) begin
            chk(done_flag == 1'b1, "R9 done flag set", int'(done_flag), 1);
            chk(irq == 1'b1, "R9 irq pulse", int'(irq), 1);
        end else begin
            chk(irq == 1'b0, "R9 no irq mid scan", int'(irq), 0);
        end
    endtask

    task automatic stop_and_clear();
        cfg_start = 1'b0;
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
        chk(!smp_en && !conv_go, "R7 parked after stop", int'({smp_en, conv_go}), 0);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(done_flag == 1'b1, "R10 clear without read ignored", int'(done_flag), 1);
        flag_rd = 1'b1;
        step();
        flag_rd = 1'b0;
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(done_flag == 1'b0, "R10 clear after read", int'(done_flag), 0);
        repeat (LAT + 3) step();
    endtask

    task automatic run_scan(input int last, input int idle, input bit retrig);
        int eff;
        repeat (idle) step();
        eff = (last > NCH - 1) ? NCH - 1 : last;
        start_scan(last, retrig, (last > NCH - 1) ? "R6 clamped set delay" : "R2 start delay");
        for (int pass = 0; pass < 2; pass++) begin
            for (int ch = 0; ch <= eff; ch++) begin
                conv_body(ch, eff, pass == 0 && ch == 0);
            end
        end
        stop_and_clear();
    endtask

    initial begin
        logic [DW-1:0] prior;
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!smp_en && !conv_go && !irq && !done_flag, "R1 outputs low",
            int'({smp_en, conv_go, irq, done_flag}), 0);
        chk(ch_sel == '0, "R1 channel zero", int'(ch_sel), 0);
        for (int c = 0; c < NCH; c++) begin
            rd_ch = CH_W'(c);
            #0.1;
            chk(rd_data == '0, "R1 result cleared", int'(rd_data), 0);
        end
        step();

        // Sweep every set size (index 3 exercises the R6 clamp) over all delay phases
        for (int last = 0; last < 4; last++) begin
            for (int ph = 0; ph < SPAN; ph++) begin
                run_scan(last, ph, ph == 1);
            end
        end

        // R7 / R8: stop in the middle of channel 1, then restart
        start_scan(2, 1'b0, "R2 start delay");
        conv_body(0, 2, 1'b1);
        g = 0;
        while (!conv_go && g < 50) begin
            step();
            g++;
        end
        rd_ch = CH_W'(1);
        #0.1;
        prior = rd_data;
        cfg_start = 1'b0;
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
        chk(!smp_en && !conv_go, "R7 stop mid conversion", int'({smp_en, conv_go}), 0);
        repeat (LAT + 3) step();
        rd_ch = CH_W'(1);
        #0.1;
        chk(rd_data == prior, "R7 in-flight result dropped", int'(rd_data), int'(prior));
        chk(done_flag == 1'b0, "R7 no done after stop", int'(done_flag), 0);
        chk(ch_sel == '0, "R8 pointer reset on stop", int'(ch_sel), 0);
        start_scan(2, 1'b0, "R8 restart delay");
        for (int ch = 0; ch <= 2; ch++) conv_body(ch, 2, ch == 0);
        stop_and_clear();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule